// File: doc/BRIEF.md
# ADC Limit-Check Status Unit

This unit sits behind an analog-to-digital converter and inspects every converted result as it arrives. Each result comes with the index of one of eight sample slots. The unit compares the result, as a signed two's-complement value, against a high limit and a low limit that belong to that slot. It also compares the sign of the result with the sign of the previous result in the same slot, to detect a zero crossing. Every hit sets a sticky flag. Software clears a flag by writing a one to its bit.

The flags feed one shared error interrupt. Each of the three event categories has its own enable bit. A category that is disabled still records its flags, but it cannot raise the interrupt. The limits, the enables and both status words are reached over a plain register bus. Writes take effect at the clock edge. Reads are combinational on the address.

Top module: `adc_limit_monitor`

## Requirements
- R1: Register map by word address. Addresses 0..7 hold the high limit of slot 0..7 and addresses 8..15 hold the low limit of slot 0..7; both read back the value last written. Address 16 is the control word. Address 17 is the limit status word. Address 18 is the crossing status word. Any other address reads 0.
- R2: After reset every high limit is 0x7FFF, every low limit is 0x8000, control reads 0, both status words read 0 and `irq` is 0.
- R3: A sample whose signed value is strictly greater than its slot's high limit sets bit 8+slot of the limit status word at the clock edge that accepts the sample. A sample equal to the limit sets nothing.
- R4: A sample whose signed value is strictly below its slot's low limit sets bit slot (bits 0..7) of the limit status word. A sample equal to the limit sets nothing.
- R5: A sample sets bit slot of the crossing status word (bits 7..0, bits 15..8 read 0) only when all three of these hold: an earlier sample of the same slot was accepted since reset, neither that sample nor the current one is zero, and their signs differ. The first sample of a slot after reset never sets the bit.
- R6: Flags are sticky. Later samples that are within limits, or that do not cross zero, leave a set flag at 1.
- R7: Writing to a status word clears exactly the bits written as 1. Bits written as 0 keep their value. Writing 0xFFFF to address 17 clears every limit flag, and writing 0x00FF to address 18 clears every crossing flag.
- R8: When a sample sets a flag in the same cycle that a write of 1 clears it, the flag ends up at 1.
- R9: Control bit 8 enables the high-limit category, bit 9 the low-limit category and bit 10 the crossing category. The other control bits read 0. `irq` is a register: it is 1 exactly one clock after a cycle in which some set flag had its category enabled.
- R10: While a category's enable is 0, its flags still latch, but they hold `irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | A converted sample is present this cycle |
| smp_slot | input | 3 | Slot index of the sample |
| smp_data | input | 16 | Signed sample value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Shared limit/crossing interrupt |

## Verification
The hardest case to reach from the ports is a flag that is set by hardware and cleared by software in the same clock. The bench raises `smp_vld` with an out-of-limit value and drives a write of one to that flag's bit on the same falling edge. Both events therefore arrive at one rising edge, and the flag must stay set. The crossing detector is also hard to reach, because it depends on history that the bus cannot see. The bench builds that history with sample sequences on fresh slots: a first sample alone, a real sign change, and a path through zero. Then it reads the crossing word.

// File: rtl/adc_lim_pkg.sv
// Package: shared constants and the address decode of the limit-check unit.
// Assumes the slot count is a power of two and at most half the data width.
package adc_lim_pkg;

    // Control-word bit positions of the three category enables
    localparam int CTRL_EN_HI = 8;
    localparam int CTRL_EN_LO = 9;
    localparam int CTRL_EN_ZC = 10;

    typedef enum logic [2:0] {
        RG_HI_LIM,
        RG_LO_LIM,
        RG_CTRL,
        RG_LIM_STAT,
        RG_ZC_STAT,
        RG_NONE
    } reg_region_e;

    // Map a word address onto the register region it selects
    function automatic reg_region_e decode_addr(input int unsigned addr,
                                                input int unsigned slots);
        if (addr < slots)              return RG_HI_LIM;
        else if (addr < 2 * slots)     return RG_LO_LIM;
        else if (addr == 2 * slots)    return RG_CTRL;
        else if (addr == 2 * slots + 1) return RG_LIM_STAT;
        else if (addr == 2 * slots + 2) return RG_ZC_STAT;
        else                           return RG_NONE;
    endfunction

endpackage

// File: rtl/adc_lim_regfile.sv
// Module: holds the per-slot high and low limits and the three category
// enables, all written through the register bus.
// Assumes one write per cycle; the status words are not stored here.
module adc_lim_regfile
    import adc_lim_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  hi_lim,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  lo_lim,
    output logic                              en_hi,
    output logic                              en_lo,
    output logic                              en_zc
);

    localparam int unsigned CTRL_ADDR = 2 * NUM_SLOTS;
    localparam logic [DATA_W-1:0] HI_RST = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] LO_RST = {1'b1, {(DATA_W-1){1'b0}}};

    logic ctrl_wr;

    // Control write strobe decode
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hi_wr;
        logic lo_wr;

        // Per-slot limit write strobes
        always_comb begin
            hi_wr = bus_wr && (bus_addr == ADDR_W'(s));
            lo_wr = bus_wr && (bus_addr == ADDR_W'(NUM_SLOTS + s));
        end

        // Per-slot limit storage, reset to values that never trip
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_lim[s] <= HI_RST;
                lo_lim[s] <= LO_RST;
            end else begin
                if (hi_wr) hi_lim[s] <= bus_wdata;
                if (lo_wr) lo_lim[s] <= bus_wdata;
            end
        end
    end

    // Category enable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_hi <= 1'b0;
            en_lo <= 1'b0;
            en_zc <= 1'b0;
        end else if (ctrl_wr) begin
            en_hi <= bus_wdata[CTRL_EN_HI];
            en_lo <= bus_wdata[CTRL_EN_LO];
            en_zc <= bus_wdata[CTRL_EN_ZC];
        end
    end

endmodule

// File: rtl/adc_lim_compare.sv
// Module: evaluates one incoming sample against its slot's limits and
// against the slot's previous sample, producing one-cycle set pulses.
// Assumes limits are signed two's-complement; a slot index beyond the
// slot count matches no slot.
module adc_lim_compare #(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 16,
    parameter int SLOT_W    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              smp_vld,
    input  logic [SLOT_W-1:0]                 smp_slot,
    input  logic [DATA_W-1:0]                 smp_data,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  hi_lim,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0]  lo_lim,
    output logic [NUM_SLOTS-1:0]              set_hi,
    output logic [NUM_SLOTS-1:0]              set_lo,
    output logic [NUM_SLOTS-1:0]              set_zc
);

    logic cur_zero;
    logic cur_neg;

    // Sign and zero properties of the incoming sample
    always_comb begin
        cur_zero = (smp_data == '0);
        cur_neg  = smp_data[DATA_W-1];
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic              hit;
        logic              prev_seen;
        logic              prev_zero;
        logic              prev_neg;

        // Slot select for this sample
        always_comb begin
            hit = smp_vld && (smp_slot == SLOT_W'(s));
        end

        // Limit comparisons and sign-change detection for this slot
        always_comb begin
            set_hi[s] = hit && ($signed(smp_data) > $signed(hi_lim[s]));
            set_lo[s] = hit && ($signed(smp_data) < $signed(lo_lim[s]));
            set_zc[s] = hit && prev_seen && !prev_zero && !cur_zero
                        && (prev_neg != cur_neg);
        end

        // History of the previous accepted sample of this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_seen <= 1'b0;
                prev_zero <= 1'b1;
                prev_neg  <= 1'b0;
            end else if (hit) begin
                prev_seen <= 1'b1;
                prev_zero <= cur_zero;
                prev_neg  <= cur_neg;
            end
        end
    end

endmodule

// File: rtl/adc_lim_status.sv
// Module: sticky write-one-to-clear flags and the registered shared
// interrupt. A hardware set beats a software clear on the same bit.
// Assumes set and clear vectors are valid for one cycle each.
module adc_lim_status #(
    parameter int NUM_SLOTS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SLOTS-1:0]    set_hi,
    input  logic [NUM_SLOTS-1:0]    set_lo,
    input  logic [NUM_SLOTS-1:0]    set_zc,
    input  logic [2*NUM_SLOTS-1:0]  clr_lim,
    input  logic [NUM_SLOTS-1:0]    clr_zc,
    input  logic                    en_hi,
    input  logic                    en_lo,
    input  logic                    en_zc,
    output logic [2*NUM_SLOTS-1:0]  lim_stat,
    output logic [NUM_SLOTS-1:0]    zc_stat,
    output logic                    irq
);

    logic [2*NUM_SLOTS-1:0] set_lim;
    logic                   pend_hi;
    logic                   pend_lo;
    logic                   pend_zc;

    // Join the high and low set pulses in status-word order
    always_comb begin
        set_lim = {set_hi, set_lo};
    end

    // Sticky flags: clear the written ones, then apply set (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_stat <= '0;
            zc_stat  <= '0;
        end else begin
            lim_stat <= (lim_stat & ~clr_lim) | set_lim;
            zc_stat  <= (zc_stat & ~clr_zc) | set_zc;
        end
    end

    // Enabled pending sources per category
    always_comb begin
        pend_hi = en_hi && (|lim_stat[2*NUM_SLOTS-1:NUM_SLOTS]);
        pend_lo = en_lo && (|lim_stat[NUM_SLOTS-1:0]);
        pend_zc = en_zc && (|zc_stat);
    end

    // Registered shared interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= pend_hi || pend_lo || pend_zc;
    end

endmodule

// File: rtl/adc_limit_monitor.sv
// Module: top of the limit-check unit. Ties the limit register file, the
// sample comparator and the sticky status logic together and provides the
// combinational read port of the register bus.
// Assumes DATA_W >= 2*NUM_SLOTS and DATA_W >= 11.
module adc_limit_monitor
    import adc_lim_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_vld,
    input  logic [SLOT_W-1:0] smp_slot,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int unsigned LSTAT_ADDR = 2 * NUM_SLOTS + 1;
    localparam int unsigned ZSTAT_ADDR = 2 * NUM_SLOTS + 2;

    logic [NUM_SLOTS-1:0][DATA_W-1:0] hi_lim;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] lo_lim;
    logic                             en_hi;
    logic                             en_lo;
    logic                             en_zc;
    logic [NUM_SLOTS-1:0]             set_hi;
    logic [NUM_SLOTS-1:0]             set_lo;
    logic [NUM_SLOTS-1:0]             set_zc;
    logic [2*NUM_SLOTS-1:0]           clr_lim;
    logic [NUM_SLOTS-1:0]             clr_zc;
    logic [2*NUM_SLOTS-1:0]           lim_stat;
    logic [NUM_SLOTS-1:0]             zc_stat;
    reg_region_e                      rd_region;
    logic [ADDR_W-1:0]                rd_index;

    adc_lim_regfile #(
        .NUM_SLOTS(NUM_SLOTS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .hi_lim   (hi_lim),
        .lo_lim   (lo_lim),
        .en_hi    (en_hi),
        .en_lo    (en_lo),
        .en_zc    (en_zc)
    );

    adc_lim_compare #(
        .NUM_SLOTS(NUM_SLOTS),
        .DATA_W   (DATA_W),
        .SLOT_W   (SLOT_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp_slot(smp_slot),
        .smp_data(smp_data),
        .hi_lim  (hi_lim),
        .lo_lim  (lo_lim),
        .set_hi  (set_hi),
        .set_lo  (set_lo),
        .set_zc  (set_zc)
    );

    // Write-one-to-clear masks from bus writes to the status words
    always_comb begin
        clr_lim = '0;
        clr_zc  = '0;
        if (bus_wr && bus_addr == ADDR_W'(LSTAT_ADDR)) clr_lim = bus_wdata[2*NUM_SLOTS-1:0];
        if (bus_wr && bus_addr == ADDR_W'(ZSTAT_ADDR)) clr_zc  = bus_wdata[NUM_SLOTS-1:0];
    end

    adc_lim_status #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hi  (set_hi),
        .set_lo  (set_lo),
        .set_zc  (set_zc),
        .clr_lim (clr_lim),
        .clr_zc  (clr_zc),
        .en_hi   (en_hi),
        .en_lo   (en_lo),
        .en_zc   (en_zc),
        .lim_stat(lim_stat),
        .zc_stat (zc_stat),
        .irq     (irq)
    );

    // Region decode for the read port
    always_comb begin
        rd_region = decode_addr(int'(bus_addr), NUM_SLOTS);
        rd_index  = (rd_region == RG_LO_LIM) ? bus_addr - ADDR_W'(NUM_SLOTS) : bus_addr;
    end

    // Combinational read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (rd_region)
            RG_HI_LIM:   bus_rdata = hi_lim[rd_index[SLOT_W-1:0]];
            RG_LO_LIM:   bus_rdata = lo_lim[rd_index[SLOT_W-1:0]];
            RG_CTRL: begin
                bus_rdata[CTRL_EN_HI] = en_hi;
                bus_rdata[CTRL_EN_LO] = en_lo;
                bus_rdata[CTRL_EN_ZC] = en_zc;
            end
            RG_LIM_STAT: bus_rdata = DATA_W'(lim_stat);
            RG_ZC_STAT:  bus_rdata = DATA_W'(zc_stat);
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/adc_limit_monitor_chk.sv
// Module: property checker for the limit-check unit, bound to the top.
// Assumes it sees the top's ports and its internal set/status/limit nets.
module adc_limit_monitor_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 5,
    parameter int SLOT_W    = 3
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             smp_vld,
    input logic [SLOT_W-1:0]                smp_slot,
    input logic [DATA_W-1:0]                smp_data,
    input logic                             bus_wr,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [DATA_W-1:0]                bus_wdata,
    input logic [NUM_SLOTS-1:0][DATA_W-1:0] hi_lim,
    input logic [NUM_SLOTS-1:0][DATA_W-1:0] lo_lim,
    input logic [NUM_SLOTS-1:0]             set_hi,
    input logic [NUM_SLOTS-1:0]             set_lo,
    input logic [2*NUM_SLOTS-1:0]           lim_stat,
    input logic [NUM_SLOTS-1:0]             zc_stat,
    input logic                             en_hi,
    input logic                             en_lo,
    input logic                             en_zc,
    input logic                             irq
);

    logic                   wr_lstat;
    logic [2*NUM_SLOTS-1:0] set_all;
    logic                   pending;

    always_comb begin
        wr_lstat = bus_wr && (bus_addr == ADDR_W'(2 * NUM_SLOTS + 1));
        set_all  = {set_hi, set_lo};
        pending  = (en_hi && (|lim_stat[2*NUM_SLOTS-1:NUM_SLOTS]))
                || (en_lo && (|lim_stat[NUM_SLOTS-1:0]))
                || (en_zc && (|zc_stat));
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        p_hi_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && smp_slot == SLOT_W'(s) && $signed(smp_data) > $signed(hi_lim[s]))
            |=> lim_stat[NUM_SLOTS + s]);
        p_lo_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_vld && smp_slot == SLOT_W'(s) && $signed(smp_data) < $signed(lo_lim[s]))
            |=> lim_stat[s]);
    end

    for (genvar b = 0; b < 2 * NUM_SLOTS; b++) begin : g_bit
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (lim_stat[b] && !(wr_lstat && bus_wdata[b])) |=> lim_stat[b]);
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_lstat && bus_wdata[b] && !set_all[b]) |=> !lim_stat[b]);
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_all[b] |=> lim_stat[b]);
    end

    p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(pending)));

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_hi && !en_lo && !en_zc) |=> !irq);

endmodule

bind adc_limit_monitor adc_limit_monitor_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SLOT_W   (SLOT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (smp_vld),
    .smp_slot (smp_slot),
    .smp_data (smp_data),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .hi_lim   (hi_lim),
    .lo_lim   (lo_lim),
    .set_hi   (set_hi),
    .set_lo   (set_lo),
    .lim_stat (lim_stat),
    .zc_stat  (zc_stat),
    .en_hi    (en_hi),
    .en_lo    (en_lo),
    .en_zc    (en_zc),
    .irq      (irq)
);

// File: tb/adc_limit_monitor_test.sv
// Directed bench for the limit-check unit: one task per scenario.
module adc_limit_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [2:0]  smp_slot = '0;
    logic [15:0] smp_data = '0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;

    localparam logic [4:0] A_CTRL  = 5'd16;
    localparam logic [4:0] A_LSTAT = 5'd17;
    localparam logic [4:0] A_ZSTAT = 5'd18;

    always #2 clk = ~clk;

    adc_limit_monitor uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_slot (smp_slot),
        .smp_data (smp_data),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic smp(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        smp_vld = 1'b1; smp_slot = s; smp_data = v;
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        rd(5'd0, d);   chk("R2", "high limit reset", d, 16'h7FFF);
        rd(5'd15, d);  chk("R2", "low limit reset", d, 16'h8000);
        rd(A_CTRL, d); chk("R2", "control reset", d, 16'h0000);
        rd(A_LSTAT, d); chk("R2", "limit status reset", d, 16'h0000);
        rd(A_ZSTAT, d); chk("R2", "crossing status reset", d, 16'h0000);
        chk("R2", "irq reset", {15'd0, irq}, 16'h0000);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        do_reset();
        wr(5'd3, 16'h1234);  rd(5'd3, d);  chk("R1", "high limit slot3", d, 16'h1234);
        wr(5'd12, 16'hFF00); rd(5'd12, d); chk("R1", "low limit slot4", d, 16'hFF00);
        rd(5'd4, d); chk("R1", "high limit slot4 untouched", d, 16'h7FFF);
        rd(5'd31, d); chk("R1", "unmapped read", d, 16'h0000);
        wr(A_CTRL, 16'hFFFF); rd(A_CTRL, d); chk("R9", "control readback", d, 16'h0700);
    endtask

    task automatic t_high();
        logic [15:0] d;
        do_reset();
        wr(5'd2, 16'd100);
        smp(3'd2, 16'd100); rd(A_LSTAT, d); chk("R3", "equal to high limit", d, 16'h0000);
        smp(3'd2, 16'd101); rd(A_LSTAT, d); chk("R3", "above high limit", d, 16'h0400);
        wr(5'd1, 16'hFFCE);
        smp(3'd1, 16'hFFCF); rd(A_LSTAT, d); chk("R3", "negative high limit", d, 16'h0600);
        smp(3'd2, 16'd5); rd(A_LSTAT, d); chk("R6", "sticky after in-range sample", d, 16'h0600);
    endtask

    task automatic t_low();
        logic [15:0] d;
        do_reset();
        wr(5'd14, 16'hFF38);
        smp(3'd6, 16'hFF38); rd(A_LSTAT, d); chk("R4", "equal to low limit", d, 16'h0000);
        smp(3'd6, 16'hFF37); rd(A_LSTAT, d); chk("R4", "below low limit", d, 16'h0040);
    endtask

    task automatic t_zc();
        logic [15:0] d;
        do_reset();
        smp(3'd4, 16'd10); rd(A_ZSTAT, d); chk("R5", "first sample no crossing", d, 16'h0000);
        smp(3'd4, 16'hFFFB); rd(A_ZSTAT, d); chk("R5", "sign change slot4", d, 16'h0010);
        smp(3'd3, 16'd7); smp(3'd3, 16'd0); smp(3'd3, 16'hFFF9);
        rd(A_ZSTAT, d); chk("R5", "path through zero", d, 16'h0010);
        smp(3'd3, 16'd9); rd(A_ZSTAT, d); chk("R5", "sign change slot3", d, 16'h0018);
        smp(3'd4, 16'hFFF0); rd(A_ZSTAT, d); chk("R6", "crossing flag sticky", d, 16'h0018);
    endtask

    task automatic t_w1c();
        logic [15:0] d;
        do_reset();
        wr(5'd0, 16'd0); wr(5'd8, 16'd0);
        smp(3'd0, 16'd1); smp(3'd0, 16'hFFFF);
        rd(A_LSTAT, d); chk("R7", "setup both flags", d, 16'h0101);
        wr(A_LSTAT, 16'h0000); rd(A_LSTAT, d); chk("R7", "write zero no effect", d, 16'h0101);
        wr(A_LSTAT, 16'h0100); rd(A_LSTAT, d); chk("R7", "clear single bit", d, 16'h0001);
        wr(A_LSTAT, 16'hFFFF); rd(A_LSTAT, d); chk("R7", "clear all limit", d, 16'h0000);
        rd(A_ZSTAT, d); chk("R5", "crossing slot0 set", d, 16'h0001);
        wr(A_ZSTAT, 16'h00FF); rd(A_ZSTAT, d); chk("R7", "clear all crossing", d, 16'h0000);
    endtask

    task automatic t_set_wins();
        logic [15:0] d;
        do_reset();
        wr(5'd0, 16'd0);
        @(negedge clk);
        smp_vld = 1'b1; smp_slot = 3'd0; smp_data = 16'd50;
        bus_wr = 1'b1; bus_addr = A_LSTAT; bus_wdata = 16'h0100;
        @(negedge clk);
        smp_vld = 1'b0; bus_wr = 1'b0;
        rd(A_LSTAT, d); chk("R8", "set beats clear", d, 16'h0100);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        do_reset();
        wr(5'd0, 16'd0);
        smp(3'd0, 16'd5);
        @(negedge clk);
        chk("R10", "disabled flag no irq", {15'd0, irq}, 16'h0000);
        rd(A_LSTAT, d); chk("R10", "disabled flag latched", d, 16'h0100);
        wr(A_CTRL, 16'h0100);
        chk("R9", "irq not yet after enable", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        chk("R9", "irq one clock after enable", {15'd0, irq}, 16'h0001);
        wr(A_LSTAT, 16'hFFFF);
        @(negedge clk);
        chk("R9", "irq drops after clear", {15'd0, irq}, 16'h0000);
        wr(A_CTRL, 16'h0200);
        wr(5'd15, 16'd0);
        smp(3'd7, 16'hFFFF);
        chk("R9", "irq lags status", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        chk("R9", "low category irq", {15'd0, irq}, 16'h0001);
        wr(A_CTRL, 16'h0000);
        @(negedge clk);
        chk("R10", "enable cleared masks irq", {15'd0, irq}, 16'h0000);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog: got=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_regs();
        t_high();
        t_low();
        t_zc();
        t_w1c();
        t_set_wins();
        t_irq();
        finish_run();
    end

endmodule